// File: doc/BRIEF.md
# Switchable Dot-Product / Maximum Reduction Tile

This tile is the arithmetic core of a neural-network layer engine. Each accepted beat carries one input word of `TN` signed 16-bit values, which are the `TN` channels of a single pixel. It also carries one weight word of `TN`×`TN` signed 16-bit values and a word of `TN` signed 32-bit partial sums. In dot mode, each output lane `o` multiplies every input channel by that lane's own weights and reduces the products through a binary adder tree. The lane then adds the partial sum fetched from the output buffer. The result is returned at 32 bits for write-back, and also clamped to 16 bits for use as a final neuron value. In max mode, the same tree acts as a comparison tree and returns the largest input channel for pooling. In that mode the weights and partial sums are not used.

A `first` flag starts a new accumulation from zero instead of the stored partial sum. A `last` flag travels with the beat and marks the result as final. Both the input and the output are valid/ready streams. The pipeline stalls as one unit: while a result is valid and not taken, every stage holds and `in_ready` is low. When the output is taken or empty, `in_ready` is high in the same cycle. `in_ready` therefore depends combinationally on `out_ready` and on the registered `out_valid`. A producer may hold `in_valid` for as long as it wants. A beat counts as accepted only on an edge where both `in_valid` and `in_ready` are high.

Top module: `dot_max_tile`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_mode`=0, lane `o` of `out_acc` (bits `[o*32 +: 32]`) equals base + Σk w(o,k)·x(k). Here x(k) is `in_x[k*16 +: 16]`, w(o,k) is `in_w[(o*TN+k)*16 +: 16]`, and all values are signed.
- R3: In dot mode, base is 0 when `in_first`=1, so `in_psum` is ignored. Otherwise base is lane `o` of `in_psum` (bits `[o*32 +: 32]`, signed).
- R4: The dot-mode sum is saturated to the signed 32-bit range (0x7FFFFFFF / 0x80000000) rather than wrapping.
- R5: Lane `o` of `out_res` (bits `[o*16 +: 16]`) equals lane `o` of `out_acc` clamped to the signed 16-bit range.
- R6: With `in_mode`=1, every lane of `out_acc` and `out_res` equals the largest signed x(k). `in_w`, `in_psum` and `in_first` have no effect.
- R7: With `out_ready` held at 1, a beat accepted on edge E appears with `out_valid`=1 right after edge E+log2(TN)+1, so the latency is log2(TN)+2 edges. One beat per cycle is sustained.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_acc`, `out_res` and `out_last` hold their values.
- R9: `out_last` equals the `in_last` of the same beat.
- R10: Results leave in acceptance order, one per accepted beat, with none dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Tile can accept a beat |
| in_mode | input | 1 | 0 = dot product, 1 = maximum |
| in_first | input | 1 | Start accumulation from zero |
| in_last | input | 1 | Marks this beat's result as final |
| in_x | input | TN*16 | Input channels of one pixel |
| in_w | input | TN*TN*16 | Weights, output-lane major |
| in_psum | input | TN*32 | Partial sums read back from the output buffer |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_last | output | 1 | Final-result marker |
| out_acc | output | TN*32 | Saturated 32-bit results / partial sums |
| out_res | output | TN*16 | Results clamped to 16 bits |

## Verification
Several rules are checked by assertions on every cycle. Stalled outputs must hold steady. The 16-bit clamp must agree with the 32-bit result at both rails. Max-mode results must stay inside the 16-bit range. The number of beats in flight can never exceed the pipeline depth, and no result may appear with nothing in flight. Only the bench scenarios can show the arithmetic itself. These scenarios cover the lane and weight ordering, the choice between partial sum and zero, saturation at both 32-bit rails, and the independence of max mode from weights. They also cover the exact latency at full rate and in-order delivery under random gaps and back-pressure.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic {
    OP_DOT = 1'b0,
    OP_MAX = 1'b1
  } op_e;
endpackage

// File: rtl/dmt_leaf.sv
// Leaf stage: forms every weighted product (or forwards the raw input in max mode)
module dmt_leaf
  import dmt_pkg::*;
#(
  parameter int TN = 4,
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int TW = 34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 v_i,
  input  op_e                  mode_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic [TN*DW-1:0]     x_i,
  input  logic [TN*TN*DW-1:0]  w_i,
  input  logic [TN*AW-1:0]     ps_i,
  output logic                 v_o,
  output op_e                  mode_o,
  output logic                 first_o,
  output logic                 last_o,
  output logic [TN*AW-1:0]     ps_o,
  output logic [TN*TN*TW-1:0]  leaf_o
);
  localparam int PW = 2 * DW;

  logic [TN*TN*TW-1:0] leaf_d;

  for (genvar o = 0; o < TN; o++) begin : g_lane
    for (genvar k = 0; k < TN; k++) begin : g_in
      logic signed [DW-1:0] xv, wv;
      logic signed [PW-1:0] prod;
      assign xv   = x_i[k*DW +: DW];
      assign wv   = w_i[(o*TN+k)*DW +: DW];
      assign prod = xv * wv;
      assign leaf_d[(o*TN+k)*TW +: TW] = (mode_i == OP_MAX)
          ? {{(TW-DW){xv[DW-1]}}, xv}
          : {{(TW-PW){prod[PW-1]}}, prod};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else if (en) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      mode_o  <= mode_i;
      first_o <= first_i;
      last_o  <= last_i;
      ps_o    <= ps_i;
      leaf_o  <= leaf_d;
    end
  end
endmodule

// File: rtl/dmt_tree.sv
// Shared reduction tree: each level adds or takes the maximum of pairs, one register per level
module dmt_tree
  import dmt_pkg::*;
#(
  parameter int TN = 4,
  parameter int AW = 32,
  parameter int TW = 34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 v_i,
  input  op_e                  mode_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic [TN*AW-1:0]     ps_i,
  input  logic [TN*TN*TW-1:0]  leaf_i,
  output logic                 v_o,
  output op_e                  mode_o,
  output logic                 first_o,
  output logic                 last_o,
  output logic [TN*AW-1:0]     ps_o,
  output logic [TN*TW-1:0]     sum_o
);
  localparam int L = $clog2(TN);

  logic signed [TW-1:0] lf [TN][TN];
  logic signed [TW-1:0] nd [L][TN][TN];
  logic [L-1:0]         vq, fq, lq;
  op_e                  mq [L];
  logic [TN*AW-1:0]     psq [L];

  function automatic logic signed [TW-1:0] pair(op_e m, logic signed [TW-1:0] a,
                                                 logic signed [TW-1:0] b);
    if (m == OP_MAX) return (a > b) ? a : b;
    return a + b;
  endfunction

  always_comb begin
    for (int o = 0; o < TN; o++)
      for (int k = 0; k < TN; k++)
        lf[o][k] = leaf_i[(o*TN+k)*TW +: TW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vq <= '0;
    else if (en) begin
      vq[0] <= v_i;
      for (int l = 1; l < L; l++) vq[l] <= vq[l-1];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      mq[0]  <= mode_i;
      fq[0]  <= first_i;
      lq[0]  <= last_i;
      psq[0] <= ps_i;
      for (int o = 0; o < TN; o++)
        for (int j = 0; j < TN/2; j++)
          nd[0][o][j] <= pair(mode_i, lf[o][2*j], lf[o][2*j+1]);
      for (int l = 1; l < L; l++) begin
        mq[l]  <= mq[l-1];
        fq[l]  <= fq[l-1];
        lq[l]  <= lq[l-1];
        psq[l] <= psq[l-1];
        for (int o = 0; o < TN; o++)
          for (int j = 0; j < (TN >> (l+1)); j++)
            nd[l][o][j] <= pair(mq[l-1], nd[l-1][o][2*j], nd[l-1][o][2*j+1]);
      end
    end
  end

  for (genvar o = 0; o < TN; o++) begin : g_root
    assign sum_o[o*TW +: TW] = nd[L-1][o][0];
  end

  assign v_o     = vq[L-1];
  assign mode_o  = mq[L-1];
  assign first_o = fq[L-1];
  assign last_o  = lq[L-1];
  assign ps_o    = psq[L-1];
endmodule

// File: rtl/dmt_accum.sv
// Final stage: merges the partial sum, saturates to 32 bits, clamps to 16 bits
module dmt_accum
  import dmt_pkg::*;
#(
  parameter int TN = 4,
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int TW = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              v_i,
  input  op_e               mode_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [TN*AW-1:0]  ps_i,
  input  logic [TN*TW-1:0]  sum_i,
  output logic              out_valid,
  output logic              out_last,
  output logic [TN*AW-1:0]  out_acc,
  output logic [TN*DW-1:0]  out_res
);
  localparam int FW = ((TW > AW) ? TW : AW) + 1;
  localparam logic signed [FW-1:0] AMAX = {{(FW-AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [FW-1:0] AMIN = {{(FW-AW+1){1'b1}}, {(AW-1){1'b0}}};
  localparam logic signed [AW-1:0] DMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] DMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [TN*AW-1:0] acc_d;
  logic [TN*DW-1:0] res_d;
  logic             add_ps;
  op_e              mode_q;

  assign add_ps = (mode_i == OP_DOT) && !first_i;

  for (genvar o = 0; o < TN; o++) begin : g_lane
    logic signed [TW-1:0] s;
    logic signed [AW-1:0] b, a;
    logic signed [FW-1:0] t;
    assign s = sum_i[o*TW +: TW];
    assign b = ps_i[o*AW +: AW];
    assign t = {{(FW-TW){s[TW-1]}}, s}
             + (add_ps ? {{(FW-AW){b[AW-1]}}, b} : {FW{1'b0}});
    assign a = (t > AMAX) ? AMAX[AW-1:0] : (t < AMIN) ? AMIN[AW-1:0] : t[AW-1:0];
    assign acc_d[o*AW +: AW] = a;
    assign res_d[o*DW +: DW] = (a > DMAX) ? DMAX[DW-1:0]
                             : (a < DMIN) ? DMIN[DW-1:0] : a[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (en) out_valid <= v_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_last <= last_i;
      out_acc  <= acc_d;
      out_res  <= res_d;
      mode_q   <= mode_i;
    end
  end

  for (genvar o = 0; o < TN; o++) begin : g_chk
    logic signed [AW-1:0] qa;
    logic signed [DW-1:0] qr;
    assign qa = out_acc[o*AW +: AW];
    assign qr = out_res[o*DW +: DW];
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (qa > DMAX) |-> qr == DMAX[DW-1:0]); // R5
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (qa < DMIN) |-> qr == DMIN[DW-1:0]); // R5
    AST_CLAMP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (qa <= DMAX) && (qa >= DMIN) |-> qa == {{(AW-DW){qr[DW-1]}}, qr}); // R5
    AST_MAX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (mode_q == OP_MAX) |-> (qa <= DMAX) && (qa >= DMIN)); // R6
  end
endmodule

// File: rtl/dot_max_tile.sv
module dot_max_tile
  import dmt_pkg::*;
#(
  parameter int TN = 4,
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_mode,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic [TN*DW-1:0]     in_x,
  input  logic [TN*TN*DW-1:0]  in_w,
  input  logic [TN*AW-1:0]     in_psum,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_last,
  output logic [TN*AW-1:0]     out_acc,
  output logic [TN*DW-1:0]     out_res
);
  localparam int L   = $clog2(TN);
  localparam int TW  = 2 * DW + L;
  localparam int LAT = L + 2;

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  logic                a_v, a_f, a_l;
  op_e                 a_m;
  logic [TN*AW-1:0]    a_ps;
  logic [TN*TN*TW-1:0] a_leaf;

  logic                b_v, b_f, b_l;
  op_e                 b_m;
  logic [TN*AW-1:0]    b_ps;
  logic [TN*TW-1:0]    b_sum;

  dmt_leaf #(.TN(TN), .DW(DW), .AW(AW), .TW(TW)) u_leaf (
    .clk(clk), .rst_n(rst_n), .en(en), .v_i(in_valid), .mode_i(op_e'(in_mode)),
    .first_i(in_first), .last_i(in_last), .x_i(in_x), .w_i(in_w), .ps_i(in_psum),
    .v_o(a_v), .mode_o(a_m), .first_o(a_f), .last_o(a_l), .ps_o(a_ps), .leaf_o(a_leaf)
  );

  dmt_tree #(.TN(TN), .AW(AW), .TW(TW)) u_tree (
    .clk(clk), .rst_n(rst_n), .en(en), .v_i(a_v), .mode_i(a_m), .first_i(a_f),
    .last_i(a_l), .ps_i(a_ps), .leaf_i(a_leaf),
    .v_o(b_v), .mode_o(b_m), .first_o(b_f), .last_o(b_l), .ps_o(b_ps), .sum_o(b_sum)
  );

  dmt_accum #(.TN(TN), .DW(DW), .AW(AW), .TW(TW)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(en), .v_i(b_v), .mode_i(b_m), .first_i(b_f),
    .last_i(b_l), .ps_i(b_ps), .sum_i(b_sum),
    .out_valid(out_valid), .out_last(out_last), .out_acc(out_acc), .out_res(out_res)
  );

  // beats accepted but not yet delivered, kept only for the checks below
  logic [7:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_res)
                                && $stable(out_last)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(LAT)); // R7
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 8'd0); // R10
endmodule

// File: tb/dot_max_tile_tb.sv
module dot_max_tile_tb;
  localparam int TN  = 4;
  localparam int DW  = 16;
  localparam int AW  = 32;
  localparam int LAT = $clog2(TN) + 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_mode = 0, in_first = 0, in_last = 0, out_ready = 0;
  logic [TN*DW-1:0] in_x = '0;
  logic [TN*TN*DW-1:0] in_w = '0;
  logic [TN*AW-1:0] in_psum = '0;
  logic in_ready, out_valid, out_last;
  logic [TN*AW-1:0] out_acc;
  logic [TN*DW-1:0] out_res;

  always #2 clk = ~clk;

  dot_max_tile #(.TN(TN), .DW(DW), .AW(AW)) u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // stimulus queue
  logic s_mode[$], s_first[$], s_last[$];
  logic [TN*DW-1:0] s_x[$];
  logic [TN*TN*DW-1:0] s_w[$];
  logic [TN*AW-1:0] s_ps[$];
  string s_tag[$];
  // scoreboard
  logic [TN*AW-1:0] e_acc[$];
  logic [TN*DW-1:0] e_res[$];
  logic e_last[$];
  string e_tag[$];
  int e_edge[$];

  task automatic chk(input string req, input logic [TN*AW-1:0] act, input logic [TN*AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic void model(input logic md, input logic fst, input logic [TN*DW-1:0] x,
                                input logic [TN*TN*DW-1:0] w, input logic [TN*AW-1:0] ps,
                                output logic [TN*AW-1:0] acc, output logic [TN*DW-1:0] res);
    for (int o = 0; o < TN; o++) begin
      longint t;
      if (md) begin
        t = longint'($signed(x[0 +: DW]));
        for (int k = 1; k < TN; k++)
          if (longint'($signed(x[k*DW +: DW])) > t) t = longint'($signed(x[k*DW +: DW]));
      end else begin
        t = fst ? 0 : longint'($signed(ps[o*AW +: AW]));
        for (int k = 0; k < TN; k++)
          t += longint'($signed(x[k*DW +: DW])) * longint'($signed(w[(o*TN+k)*DW +: DW]));
      end
      if (t > 64'sd2147483647) t = 64'sd2147483647;
      if (t < -64'sd2147483648) t = -64'sd2147483648;
      acc[o*AW +: AW] = t[AW-1:0];
      if (t > 64'sd32767) t = 64'sd32767;
      if (t < -64'sd32768) t = -64'sd32768;
      res[o*DW +: DW] = t[DW-1:0];
    end
  endfunction

  task automatic push(input string tag, input logic md, input logic fst, input logic lst,
                      input logic [TN*DW-1:0] x, input logic [TN*TN*DW-1:0] w,
                      input logic [TN*AW-1:0] ps);
    s_tag.push_back(tag); s_mode.push_back(md); s_first.push_back(fst); s_last.push_back(lst);
    s_x.push_back(x); s_w.push_back(w); s_ps.push_back(ps);
  endtask

  function automatic logic [TN*DW-1:0] rx();
    logic [TN*DW-1:0] v;
    for (int k = 0; k < TN; k++) v[k*DW +: DW] = DW'($urandom);
    return v;
  endfunction
  function automatic logic [TN*TN*DW-1:0] rw();
    logic [TN*TN*DW-1:0] v;
    for (int k = 0; k < TN*TN; k++) v[k*DW +: DW] = DW'($urandom);
    return v;
  endfunction
  function automatic logic [TN*AW-1:0] rp();
    logic [TN*AW-1:0] v;
    for (int k = 0; k < TN; k++) v[k*AW +: AW] = $urandom;
    return v;
  endfunction

  task automatic push_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic md;
      md = ($urandom_range(3) == 0);
      push(md ? "R6" : "R2", md, 1'($urandom), 1'($urandom), rx(), rw(), rp());
    end
  endtask

  // drive the queue; handshakes are decided at the negedge before the edge they happen on
  task automatic run(input int gap_pct, input int ready_pct, input bit lat_chk);
    bit fire_in = 0, stalled = 0;
    logic [TN*AW-1:0] held;
    forever begin
      @(negedge clk);
      if (stalled) chk("R8 hold", out_acc, held);
      if (fire_in) in_valid = 0;
      out_ready = ($urandom_range(99) < ready_pct);
      if (!in_valid && s_tag.size() > 0 && $urandom_range(99) >= gap_pct) begin
        in_valid = 1; in_mode = s_mode[0]; in_first = s_first[0]; in_last = s_last[0];
        in_x = s_x[0]; in_w = s_w[0]; in_psum = s_ps[0];
      end
      #1;
      fire_in = in_valid && in_ready;
      if (fire_in) begin
        logic [TN*AW-1:0] a;
        logic [TN*DW-1:0] r;
        model(in_mode, in_first, in_x, in_w, in_psum, a, r);
        e_acc.push_back(a); e_res.push_back(r); e_last.push_back(in_last);
        e_tag.push_back({s_tag[0], " R10"}); e_edge.push_back(cyc + 1);
        void'(s_tag.pop_front()); void'(s_mode.pop_front()); void'(s_first.pop_front());
        void'(s_last.pop_front()); void'(s_x.pop_front()); void'(s_w.pop_front());
        void'(s_ps.pop_front());
      end
      stalled = out_valid && !out_ready;
      held = out_acc;
      if (stalled) chk("R8 in_ready", {{(TN*AW-1){1'b0}}, in_ready}, '0);
      if (out_valid && out_ready) begin
        if (e_acc.size() == 0) chk("R10 extra result", 1, 0);
        else begin
          logic [TN*AW-1:0] ea; logic [TN*DW-1:0] er; logic el; string et; int ee;
          ea = e_acc.pop_front(); er = e_res.pop_front(); el = e_last.pop_front();
          et = e_tag.pop_front(); ee = e_edge.pop_front();
          chk(et, out_acc, ea);
          chk("R5", {{(TN*AW-TN*DW){1'b0}}, out_res}, {{(TN*AW-TN*DW){1'b0}}, er});
          chk("R9", {{(TN*AW-1){1'b0}}, out_last}, {{(TN*AW-1){1'b0}}, el});
          if (lat_chk) chk("R7 latency", cyc, ee + LAT - 1);
        end
      end
      if (s_tag.size() == 0 && !in_valid && e_acc.size() == 0 && !out_valid) break;
      if (s_tag.size() == 0 && fire_in && e_acc.size() == 0) break;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [TN*DW-1:0] x;
    logic [TN*TN*DW-1:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 out_valid", {{(TN*AW-1){1'b0}}, out_valid}, '0);
    chk("R1 in_ready", {{(TN*AW-1){1'b0}}, in_ready}, 1);
    rst_n = 1;

    // R2: small known values, lane/weight ordering
    for (int k = 0; k < TN; k++) x[k*DW +: DW] = DW'(k + 1);
    for (int o = 0; o < TN; o++)
      for (int k = 0; k < TN; k++) w[(o*TN+k)*DW +: DW] = DW'((o == k) ? o + 2 : -(k + 1));
    push("R2", 0, 1, 0, x, w, rp());
    // R3: first ignores psum, then accumulate onto a psum
    push("R3", 0, 1, 1, x, w, {TN{32'h1234_5678}});
    push("R3", 0, 0, 0, x, w, {TN{32'hFFFF_FF00}});
    // R4: positive and negative saturation
    push("R4", 0, 0, 1, {TN{16'h7FFF}}, {(TN*TN){16'h7FFF}}, {TN{32'h7FFF_FFF0}});
    push("R4", 0, 0, 0, {TN{16'h8000}}, {(TN*TN){16'h7FFF}}, {TN{32'h8000_0010}});
    push("R4", 0, 1, 0, {TN{16'h8000}}, {(TN*TN){16'h8000}}, rp());
    // R6: max mode ignores weights, psum and first
    push("R6", 1, 0, 0, {16'h8000, 16'hFFFF, 16'hFF9C, 16'hFFFB}, rw(), rp());
    push("R6", 1, 1, 1, {16'h7FFF, 16'h0003, 16'h8000, 16'h0001}, rw(), rp());
    push("R6", 1, 0, 0, {TN{16'h8000}}, rw(), {TN{32'h7FFF_FFFF}});
    run(0, 100, 1);

    // R7: full-rate stream with exact latency
    push_random(40);
    run(0, 100, 1);

    // R8/R10: random gaps and back-pressure
    push_random(300);
    run(30, 45, 0);
    push_random(200);
    run(5, 85, 0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule